// File: doc/BRIEF.md
# Three-Phase Output Commutation Controller

This block turns a 3-bit rotor position pattern into the six gate-drive outputs of a three-phase motor bridge. Each of the U, V and W phases has a high-side and a low-side output. The pattern comes from one of two sources: three external sensor pins, or three bits that software writes. The external pins are brought into the clock domain and can be cleaned by a majority-free glitch filter, which samples at one of four selectable rates.

The chosen pattern is latched into an applied-phase register. This register follows the source every clock, or only at rising edges of a PWM signal from a neighbouring timer. The applied pattern drives a six-step commutation table. The table has options for:
- swapping the V and W phases,
- chopping either bridge side with the PWM,
- inverting the polarity of all six outputs.

An output-enable bit tells the pads to drive or float. Either of two group output-disable requests can clear this bit in hardware.

All control lives in one 32-bit register word. Software writes it through a single-cycle write strobe, and the read data is always presented.

Top module: `phase_commutator`

## Requirements
- R1: After reset every control field is 0, `reg_rdata` reads 0, `drv_oe` is 0 and all six drive outputs are 0.
- R2: A write loads the control fields from `reg_wdata[15:0]`, in this layout:
  - bits 2:0: software pattern, with bit 0 = U, bit 1 = V, bit 2 = W.
  - bit 3: source select.
  - bit 4: PWM alignment.
  - bit 5: V/W swap.
  - bit 6: high-side PWM.
  - bit 7: low-side PWM.
  - bit 8: invert.
  - bit 9: output enable.
  - bit 10: group-disable enable.
  - bits 12:11: group select.
  - bit 13: filter enable.
  - bits 15:14: filter rate.

  The fields read back in `reg_rdata[15:0]`. Bits 31:19 read as 0.
- R3: With source select 0 the pattern comes from `hall_in` through a two-flop synchroniser. With source select 1 it comes from the software pattern bits. `reg_rdata[18:16]` shows the selected pattern, with bit 16 = U.
- R4: With the filter enabled, a new `hall_in` level is accepted only after three consecutive equal samples, so a pulse shorter than three sample periods is rejected. With the filter disabled, the synchronised level is used directly.
- R5: Filter rate code 00, 01, 10 and 11 takes a sample every 1, 4, 16 and 64 clocks respectively.
- R6: With alignment 0, the applied pattern takes the selected pattern at every clock edge. With alignment 1, it updates only at a clock edge where `pwm_in` is high and was low at the previous edge.
- R7: The six-step table for pattern {W,V,U} maps as follows: 001 → U high + V low, 011 → U high + W low, 010 → V high + W low, 110 → V high + U low, 100 → W high + U low, 101 → W high + V low. In `drv_out`, bit 2i is the high side and bit 2i+1 is the low side of phase i (U=0, V=1, W=2).
- R8: Patterns 000 and 111 leave all six outputs inactive.
- R9: With the swap bit set, the V and W output pairs exchange their drive.
- R10: An active high-side output drives `pwm_in` when the high-side PWM bit is 1, and 1 otherwise. The low side works the same way with its own bit. Inactive outputs drive 0.
- R11: With the invert bit set, all six outputs are the complement of their active-high values.
- R12: `drv_oe` equals the output-enable bit. When it is 0 the pads are high-impedance.
- R13: When the group-disable enable is 1, a high request on the selected group clears the output-enable bit at the next edge. Group select 01 picks `grp_b_dis`; 00, 10 and 11 pick `grp_a_dis`. The other request and a disabled function have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Control fields and selected-pattern monitor |
| hall_in | input | 3 | External position inputs, bit 0 = U |
| pwm_in | input | 1 | PWM from neighbouring timer |
| grp_a_dis | input | 1 | Group A output-disable request |
| grp_b_dis | input | 1 | Group B output-disable request |
| drv_out | output | 6 | Bridge drive values, {W lo, W hi, V lo, V hi, U lo, U hi} |
| drv_oe | output | 1 | Drive enable for all six pads |

## Verification
The assertions check the following on every cycle:
- A disable hit always clears the enable.
- A write always loads the fields.
- The applied pattern stays frozen between PWM rising edges when aligned.
- A valid pattern with static drive lights exactly two outputs.
- Invalid patterns leave every output at the inactive level.
- The filter output moves only on sample ticks.

Only the bench scenarios can show the following:
- The exact six-step assignment, and the effect of the V/W swap.
- Which group each select code picks.
- That a short glitch is rejected.
- That each filter rate code gives the right acceptance delay.

// File: rtl/pc_pkg.sv
package pc_pkg;
   localparam int REG_W = 32;
   localparam int PAT_W = 3;

   localparam logic [1:0] GRP_SEL_B = 2'b01;

   typedef struct packed {
      logic [1:0] flt_rate;
      logic       flt_en;
      logic [1:0] grp_sel;
      logic       grp_dis_en;
      logic       out_en;
      logic       invert;
      logic       lo_pwm;
      logic       hi_pwm;
      logic       swap_vw;
      logic       align_pwm;
      logic       src_soft;
      logic [2:0] soft_pat;
   } ctl_t;

   localparam int CTL_W = $bits(ctl_t);
endpackage

// File: rtl/pc_incond.sv
module pc_incond #(
   parameter int W           = 3,
   parameter int SYNC_STAGES = 2,
   parameter int FLT_SAMPLES = 3,
   parameter int STEP_LOG2   = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] raw,
   input  logic         flt_en,
   input  logic [1:0]   flt_rate,
   output logic [W-1:0] cond
);
   localparam int PW = STEP_LOG2 * 3;

   logic [PW-1:0] pre_cnt;
   logic [PW-1:0] pre_mask;
   logic          tick;
   logic [W-1:0]  synced;
   logic [W-1:0]  flt_q;

   always_comb begin
      pre_mask = '0;
      for (int b = 0; b < PW; b++)
         pre_mask[b] = (b < STEP_LOG2 * int'(flt_rate));
   end

   assign tick = ((pre_cnt & pre_mask) == pre_mask);

   always_ff @(posedge clk) begin
      if (!rst_n) pre_cnt <= '0;
      else        pre_cnt <= pre_cnt + 1'b1;
   end

   for (genvar i = 0; i < W; i++) begin : g_bit
      logic [SYNC_STAGES-1:0] sy;
      always_ff @(posedge clk) begin
         if (!rst_n) sy <= '0;
         else        sy <= {sy[SYNC_STAGES-2:0], raw[i]};
      end
      assign synced[i] = sy[SYNC_STAGES-1];

      if (FLT_SAMPLES == 2) begin : g_short
         logic hist;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               hist     <= 1'b0;
               flt_q[i] <= 1'b0;
            end else if (tick) begin
               hist <= synced[i];
               if (hist == synced[i]) flt_q[i] <= synced[i];
            end
         end
      end else begin : g_long
         logic [FLT_SAMPLES-2:0] hist;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               hist     <= '0;
               flt_q[i] <= 1'b0;
            end else if (tick) begin
               hist <= {hist[FLT_SAMPLES-3:0], synced[i]};
               if (hist == {(FLT_SAMPLES-1){synced[i]}}) flt_q[i] <= synced[i];
            end
         end
      end
   end

   assign cond = flt_en ? flt_q : synced;

   // R5
   flt_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(flt_q) |-> $past(tick));
endmodule

// File: rtl/pc_regs.sv
module pc_regs
   import pc_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic wr,
   input  ctl_t wdata,
   input  logic grp_a,
   input  logic grp_b,
   output ctl_t ctl
);
   logic dis_hit;

   assign dis_hit = ctl.grp_dis_en && ((ctl.grp_sel == GRP_SEL_B) ? grp_b : grp_a);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctl <= '0;
      end else begin
         if (wr)      ctl        <= wdata;
         if (dis_hit) ctl.out_en <= 1'b0;
      end
   end

   // R13
   oe_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dis_hit |=> !ctl.out_en);

   // R2
   wr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && !dis_hit) |=> (ctl == $past(wdata)));
endmodule

// File: rtl/pc_map.sv
module pc_map (
   input  logic [2:0] pat,
   input  logic       swap_vw,
   input  logic       hi_pwm,
   input  logic       lo_pwm,
   input  logic       invert,
   input  logic       pwm,
   output logic [5:0] drv
);
   logic [2:0] hi_oh, lo_oh;
   logic       hi_lvl, lo_lvl;

   always_comb begin
      unique case (pat)
         3'b001:  begin hi_oh = 3'b001; lo_oh = 3'b010; end
         3'b011:  begin hi_oh = 3'b001; lo_oh = 3'b100; end
         3'b010:  begin hi_oh = 3'b010; lo_oh = 3'b100; end
         3'b110:  begin hi_oh = 3'b010; lo_oh = 3'b001; end
         3'b100:  begin hi_oh = 3'b100; lo_oh = 3'b001; end
         3'b101:  begin hi_oh = 3'b100; lo_oh = 3'b010; end
         default: begin hi_oh = 3'b000; lo_oh = 3'b000; end
      endcase
   end

   assign hi_lvl = hi_pwm ? pwm : 1'b1;
   assign lo_lvl = lo_pwm ? pwm : 1'b1;

   for (genvar i = 0; i < 3; i++) begin : g_phase
      localparam int ALT = (3 - i) % 3;
      logic on_hi, on_lo;
      assign on_hi      = swap_vw ? hi_oh[ALT] : hi_oh[i];
      assign on_lo      = swap_vw ? lo_oh[ALT] : lo_oh[i];
      assign drv[2*i]   = invert ^ (on_hi & hi_lvl);
      assign drv[2*i+1] = invert ^ (on_lo & lo_lvl);
   end

   // R7
   always_comb begin
      pair_oh_chk: assert ($onehot0(hi_oh) && ((hi_oh & lo_oh) == 3'b000));
   end
endmodule

// File: rtl/phase_commutator.sv
module phase_commutator
   import pc_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int FLT_SAMPLES = 3,
   parameter int STEP_LOG2   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [REG_W-1:0]  reg_wdata,
   output logic [REG_W-1:0]  reg_rdata,
   input  logic [PAT_W-1:0]  hall_in,
   input  logic              pwm_in,
   input  logic              grp_a_dis,
   input  logic              grp_b_dis,
   output logic [2*PAT_W-1:0] drv_out,
   output logic              drv_oe
);
   localparam int RSV_W = REG_W - CTL_W - PAT_W;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (FLT_SAMPLES < 2) begin : g_bad_flt
      $error("FLT_SAMPLES must be at least 2");
   end
   if (STEP_LOG2 < 1) begin : g_bad_step
      $error("STEP_LOG2 must be at least 1");
   end
   if (RSV_W < 0) begin : g_bad_word
      $error("control fields do not fit the register word");
   end

   ctl_t             ctl;
   logic [PAT_W-1:0] ext_pat;
   logic [PAT_W-1:0] sel_pat;
   logic [PAT_W-1:0] cur_pat;
   logic             pwm_q;
   logic             pwm_rise;
   logic             unused_hi_bits;

   assign unused_hi_bits = ^reg_wdata[REG_W-1:CTL_W];

   pc_regs u_regs (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (reg_wr),
      .wdata (ctl_t'(reg_wdata[CTL_W-1:0])),
      .grp_a (grp_a_dis),
      .grp_b (grp_b_dis),
      .ctl   (ctl)
   );

   pc_incond #(
      .W           (PAT_W),
      .SYNC_STAGES (SYNC_STAGES),
      .FLT_SAMPLES (FLT_SAMPLES),
      .STEP_LOG2   (STEP_LOG2)
   ) u_incond (
      .clk      (clk),
      .rst_n    (rst_n),
      .raw      (hall_in),
      .flt_en   (ctl.flt_en),
      .flt_rate (ctl.flt_rate),
      .cond     (ext_pat)
   );

   assign sel_pat  = ctl.src_soft ? ctl.soft_pat : ext_pat;
   assign pwm_rise = pwm_in && !pwm_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pwm_q   <= 1'b0;
         cur_pat <= '0;
      end else begin
         pwm_q <= pwm_in;
         if (!ctl.align_pwm || pwm_rise) cur_pat <= sel_pat;
      end
   end

   pc_map u_map (
      .pat     (cur_pat),
      .swap_vw (ctl.swap_vw),
      .hi_pwm  (ctl.hi_pwm),
      .lo_pwm  (ctl.lo_pwm),
      .invert  (ctl.invert),
      .pwm     (pwm_in),
      .drv     (drv_out)
   );

   assign drv_oe    = ctl.out_en;
   assign reg_rdata = {{RSV_W{1'b0}}, sel_pat, ctl};

   // R6
   phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl.align_pwm && !(pwm_in && !pwm_q)) |=> $stable(cur_pat));

   // R7
   step_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctl.hi_pwm && !ctl.lo_pwm && !ctl.invert && cur_pat != 3'b000 && cur_pat != 3'b111)
      |-> ($countones(drv_out) == 2));

   // R8
   idle_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_pat == 3'b000 || cur_pat == 3'b111) |-> (drv_out == {6{ctl.invert}}));
endmodule

// File: tb/tb_phase_commutator.sv
module tb_phase_commutator;
   localparam logic [15:0] B_SRC  = 16'h0008;
   localparam logic [15:0] B_ALN  = 16'h0010;
   localparam logic [15:0] B_SWP  = 16'h0020;
   localparam logic [15:0] B_HP   = 16'h0040;
   localparam logic [15:0] B_LP   = 16'h0080;
   localparam logic [15:0] B_INV  = 16'h0100;
   localparam logic [15:0] B_OE   = 16'h0200;
   localparam logic [15:0] B_GDE  = 16'h0400;
   localparam logic [15:0] B_FEN  = 16'h2000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [2:0]  hall_in = '0;
   logic        pwm_in = 1'b0;
   logic        grp_a_dis = 1'b0;
   logic        grp_b_dis = 1'b0;
   logic [5:0]  drv_out;
   logic        drv_oe;

   int n_cmp = 0;
   int n_bad = 0;
   int cyc = 0;
   bit done = 0;

   typedef struct {
      int          due;
      string       req;
      logic [31:0] rd;
      logic [31:0] rd_mask;
      logic [5:0]  drv;
      logic [5:0]  drv_mask;
      logic        oe;
   } item_t;
   item_t sbq[$];

   phase_commutator dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .hall_in(hall_in), .pwm_in(pwm_in),
      .grp_a_dis(grp_a_dis), .grp_b_dis(grp_b_dis),
      .drv_out(drv_out), .drv_oe(drv_oe)
   );

   always #4 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   function automatic logic [5:0] model(logic [2:0] p, bit swp, bit hp, bit lp, bit inv, bit pwm);
      int hi, lo;
      logic [5:0] r;
      case (p)
         3'b001: begin hi = 0; lo = 1; end
         3'b011: begin hi = 0; lo = 2; end
         3'b010: begin hi = 1; lo = 2; end
         3'b110: begin hi = 1; lo = 0; end
         3'b100: begin hi = 2; lo = 0; end
         3'b101: begin hi = 2; lo = 1; end
         default: begin hi = -1; lo = -1; end
      endcase
      r = '0;
      if (hi >= 0) begin
         if (swp) begin
            if (hi != 0) hi = 3 - hi;
            if (lo != 0) lo = 3 - lo;
         end
         r[2*hi]   = hp ? pwm : 1'b1;
         r[2*lo+1] = lp ? pwm : 1'b1;
      end
      return inv ? ~r : r;
   endfunction

   // monitor: pops items when due and compares
   always @(negedge clk) begin
      if (sbq.size() > 0 && sbq[0].due == cyc) begin
         item_t it;
         it = sbq[0];
         n_cmp++;
         if (((reg_rdata & it.rd_mask) != (it.rd & it.rd_mask)) ||
             ((drv_out & it.drv_mask) != (it.drv & it.drv_mask)) ||
             (drv_oe !== it.oe)) begin
            n_bad++;
            $display("FAIL %s: rdata=%h drv=%b oe=%b expected rdata=%h(mask %h) drv=%b(mask %b) oe=%b",
                     it.req, reg_rdata, drv_out, drv_oe, it.rd, it.rd_mask, it.drv, it.drv_mask, it.oe);
         end
         void'(sbq.pop_front());
      end
   end

   task automatic expect_at(input string req, input int settle, input logic [31:0] rd,
                            input logic [31:0] rdm, input logic [5:0] drv,
                            input logic [5:0] drvm, input logic oe);
      item_t it;
      it.due = cyc + settle; it.req = req; it.rd = rd; it.rd_mask = rdm;
      it.drv = drv; it.drv_mask = drvm; it.oe = oe;
      sbq.push_back(it);
      wait (sbq.size() == 0);
   endtask

   task automatic wr(input logic [15:0] v);
      @(negedge clk);
      reg_wr = 1'b1;
      reg_wdata = {16'h0, v};
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic finish_run();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: run did not complete");
         finish_run();
      end
   end

   initial begin
      logic [2:0] pats [6];
      logic [15:0] v;
      pats = '{3'b001, 3'b011, 3'b010, 3'b110, 3'b100, 3'b101};
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      expect_at("R1", 1, 32'h0, 32'hFFFF_FFFF, 6'b0, 6'h3F, 1'b0);

      // R2 all fields set; reserved reads 0; 111 invalid and inverted (R8, R11)
      wr(16'hFFFF);
      expect_at("R2", 2, 32'h0007_FFFF, 32'hFFFF_FFFF, 6'h3F, 6'h3F, 1'b1);

      // R7 six-step table, R3 monitor of software pattern
      foreach (pats[k]) begin
         v = {13'h0, pats[k]} | B_SRC | B_OE;
         wr(v);
         expect_at("R7", 2, {13'h0, pats[k], v}, 32'hFFFF_FFFF,
                   model(pats[k], 0, 0, 0, 0, 0), 6'h3F, 1'b1);
      end

      // R8 pattern 000
      wr(B_SRC | B_OE);
      expect_at("R8", 2, {16'h0, B_SRC | B_OE}, 32'hFFFF_FFFF, 6'b0, 6'h3F, 1'b1);

      // R9 swap
      foreach (pats[k]) begin
         v = {13'h0, pats[k]} | B_SRC | B_OE | B_SWP;
         wr(v);
         expect_at("R9", 2, {13'h0, pats[k], v}, 32'hFFFF_FFFF,
                   model(pats[k], 1, 0, 0, 0, 0), 6'h3F, 1'b1);
      end

      // R10 PWM on both sides
      wr(16'h0001 | B_SRC | B_OE | B_HP | B_LP);
      @(negedge clk); pwm_in = 1'b1;
      expect_at("R10", 1, 32'h0, 32'h0, 6'b001001, 6'h3F, 1'b1);
      pwm_in = 1'b0;
      expect_at("R10", 1, 32'h0, 32'h0, 6'b000000, 6'h3F, 1'b1);
      wr(16'h0001 | B_SRC | B_OE | B_LP);
      expect_at("R10", 2, 32'h0, 32'h0, 6'b000001, 6'h3F, 1'b1);

      // R11 invert
      wr(16'h0002 | B_SRC | B_OE | B_INV);
      expect_at("R11", 2, 32'h0, 32'h0, ~model(3'b010, 0, 0, 0, 0, 0), 6'h3F, 1'b1);

      // R12 output enable off
      wr(16'h0003 | B_SRC);
      expect_at("R12", 2, 32'h0, 32'h0, model(3'b011, 0, 0, 0, 0, 0), 6'h3F, 1'b0);

      // R6 PWM alignment
      wr(16'h0001 | B_SRC | B_OE);
      expect_at("R6", 2, 32'h0, 32'h0, model(3'b001, 0, 0, 0, 0, 0), 6'h3F, 1'b1);
      wr(16'h0002 | B_SRC | B_OE | B_ALN);
      expect_at("R6", 4, 32'h0002_0000, 32'h0007_0000, model(3'b001, 0, 0, 0, 0, 0), 6'h3F, 1'b1);
      pwm_in = 1'b1;
      expect_at("R6", 2, 32'h0, 32'h0, model(3'b010, 0, 0, 0, 0, 0), 6'h3F, 1'b1);
      pwm_in = 1'b0;

      // R13 group disable
      v = B_OE | B_GDE | 16'h0800;
      wr(v);
      grp_a_dis = 1'b1;
      expect_at("R13", 2, {16'h0, v}, 32'hFFFF_FFFF, 6'b0, 6'h0, 1'b1);
      grp_a_dis = 1'b0; grp_b_dis = 1'b1;
      expect_at("R13", 2, {16'h0, v & ~B_OE}, 32'hFFFF_FFFF, 6'b0, 6'h0, 1'b0);
      grp_b_dis = 1'b0;
      wr(B_OE | B_GDE | 16'h1000);
      grp_a_dis = 1'b1;
      expect_at("R13", 2, 32'h0, 32'h0, 6'b0, 6'h0, 1'b0);
      grp_a_dis = 1'b0;
      wr(B_OE);
      grp_a_dis = 1'b1; grp_b_dis = 1'b1;
      expect_at("R13", 2, 32'h0, 32'h0, 6'b0, 6'h0, 1'b1);
      grp_a_dis = 1'b0; grp_b_dis = 1'b0;

      // R3 external source, filter off
      hall_in = 3'b011;
      wr(B_OE);
      expect_at("R3", 5, 32'h0003_0000, 32'h0007_0000, model(3'b011, 0, 0, 0, 0, 0), 6'h3F, 1'b1);

      // R4 glitch rejection at rate 00
      wr(B_OE | B_FEN);
      @(negedge clk); hall_in = 3'b111;
      @(negedge clk); @(negedge clk); hall_in = 3'b011;
      expect_at("R4", 20, 32'h0003_0000, 32'h0007_0000, model(3'b011, 0, 0, 0, 0, 0), 6'h3F, 1'b1);
      hall_in = 3'b001;
      expect_at("R4", 12, 32'h0001_0000, 32'h0007_0000, model(3'b001, 0, 0, 0, 0, 0), 6'h3F, 1'b1);

      // R5 rate 11: every 64 clocks
      wr(B_OE | B_FEN | 16'hC000);
      hall_in = 3'b011;
      expect_at("R5", 100, 32'h0001_0000, 32'h0007_0000, 6'b0, 6'h0, 1'b1);
      expect_at("R5", 200, 32'h0003_0000, 32'h0007_0000, 6'b0, 6'h0, 1'b1);
      // R5 rate 01: every 4 clocks
      wr(B_OE | B_FEN | 16'h4000);
      hall_in = 3'b010;
      expect_at("R5", 6, 32'h0003_0000, 32'h0007_0000, 6'b0, 6'h0, 1'b1);
      expect_at("R5", 30, 32'h0002_0000, 32'h0007_0000, 6'b0, 6'h0, 1'b1);

      done = 1;
      finish_run();
   end
endmodule